// File: doc/BRIEF.md
# Dual-Clock Inter-Processor Messaging Unit

This block joins two processors that run on unrelated clocks. Each processor gets its own register port and its own interrupt line. The two ports show the same register layout, mirrored: what one side puts in a transmit slot turns up in the matching receive slot on the other side. Each slot has four independent data channels per direction and four doorbell channels per direction. A doorbell carries no payload and only raises a pending flag on the far side.

Every event that crosses between the clock domains does so as a toggle. The toggle passes through a multi-flop synchroniser and becomes a one-cycle pulse in the destination domain. A transmit word stays frozen in its source register until the far side has consumed it, so the payload bus can be sampled directly when the arrival pulse shows up. The far side consuming the word means a read of the receive register. That read travels back as an acknowledge and marks the transmit slot empty again. Each side's interrupt is the OR of its enabled status flags. Software learns through these flags when it may write, read or service a doorbell.

The register ports are plain single-cycle accesses with no back-pressure. Every access is accepted in the cycle it is presented. Read data is combinational from the address. The side effect of a read (clearing a full flag) takes place at the closing clock edge. Flow control is carried entirely by the flags. A transmit write that finds its slot occupied is discarded and recorded as an overrun. Nothing stalls the bus.

Top module: `mu_dual_clk`

## Requirements
- R1: After reset, on each side the status word reads 0x0000000F and the enable word reads 0. Status bits [3:0] are transmit-empty, [7:4] receive-full, [11:8] doorbell-pending and [15:12] overrun, one bit per channel. The interrupt output is low.
- R2: Addresses 0..3 (type 0, channel = addr[1:0]) are the transmit data slots. A word accepted on one side becomes readable at the same channel's receive address on the other side, addresses 4..7 (type 1). When it arrives, that channel's receive-full bit is set.
- R3: An accepted transmit write clears that channel's transmit-empty bit at once. The bit is set again only after the far side has read the matching receive register and the acknowledge has crossed back.
- R4: Reading a receive data address returns the stored word. If that channel's full bit was set, the read clears it.
- R5: A transmit write to a channel whose empty bit is clear is dropped. The word in flight is unchanged, and the channel's overrun bit (status bits [15:12]) is set. Writing 1 to an overrun bit at the status address (16) clears it.
- R6: Writing 1 in bit 0 to a doorbell ring address, 8..11 (type 2), sets that channel's doorbell-pending bit on the other side. It carries no data and leaves the ringing side's status unchanged.
- R7: Writing 1 in bit 0 to a doorbell address 12..15 (type 3) on the receiving side clears its pending bit. Writing 1 to status bits [11:8] at address 16 clears it as well. Reading addresses 12..15 returns the pending bit in bit 0. If an arrival falls in the same cycle as a clear, the arrival wins.
- R8: The interrupt of a side equals the OR of (status bits [11:0] AND enable bits [11:0]). The enable word sits at address 17.
- R9: Activity on one channel leaves the flags and data of every other channel unchanged.
- R10: The direction from side B to side A behaves exactly like the direction from A to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Side A clock |
| a_rst_n | input | 1 | Side A asynchronous reset, active low |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 5 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A interrupt |
| b_clk | input | 1 | Side B clock |
| b_rst_n | input | 1 | Side B asynchronous reset, active low |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 5 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two functions can meet in one cycle: a doorbell arrival crossing in from the far clock, and a local write-1-to-clear of the same pending bit. To make them meet, the bench holds a clear write on side B's port every cycle while side A rings that doorbell. The arrival is then bound to land on a clearing cycle. An in-RTL property requires the pending bit to be set in the cycle after any arrival. The bench also expects the enabled side B interrupt to be seen high for at least one cycle during the hammering, and the bit to read clear once the clears have run past the arrival.

// File: rtl/mu_pkg.sv
package mu_pkg;
  typedef enum logic [1:0] {
    CT_TX_DATA = 2'd0,
    CT_RX_DATA = 2'd1,
    CT_TX_BELL = 2'd2,
    CT_RX_BELL = 2'd3
  } chan_type_e;

  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_ENABLE = 1;
endpackage

// File: rtl/mu_tgl_sync.sv
// Toggle-to-pulse synchroniser: a level change on tog_i becomes one
// destination-clock pulse after STAGES capture flops.
module mu_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic dst_clk,
  input  logic dst_rst_n,
  input  logic tog_i,
  output logic pulse_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) pipe_q <= '0;
    else            pipe_q <= {pipe_q[STAGES-1:0], tog_i};
  end

  assign pulse_o = pipe_q[STAGES] ^ pipe_q[STAGES-1];
endmodule

// File: rtl/mu_side.sv
// One processor-facing register view: transmit slots, receive slots,
// doorbells, sticky overrun, interrupt enables.
module mu_side #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int unsigned AW     = CH_W + 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel,
  input  logic                          wr,
  input  logic [AW-1:0]                 addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic                          irq,
  output logic [NCH-1:0][DATA_W-1:0]    tx_data_o,
  output logic [NCH-1:0]                tx_tog_o,
  input  logic [NCH-1:0]                tx_ack_i,
  input  logic [NCH-1:0]                rx_arrive_i,
  input  logic [NCH-1:0][DATA_W-1:0]    rx_src_i,
  output logic [NCH-1:0]                rx_ack_tog_o,
  output logic [NCH-1:0]                db_tog_o,
  input  logic [NCH-1:0]                db_arrive_i
);
  import mu_pkg::*;

  localparam int unsigned SW = 4 * NCH;
  localparam int unsigned EW = 3 * NCH;

  // decode
  logic            ch_space;
  chan_type_e      ctype;
  logic [CH_W-1:0] ch;
  logic [NCH-1:0]  ch_oh;
  logic            stat_wr, en_wr;

  assign ch_space = ~addr[AW-1];
  assign ctype    = chan_type_e'(addr[CH_W+1:CH_W]);
  assign ch       = addr[CH_W-1:0];
  assign ch_oh    = NCH'(1) << ch;
  assign stat_wr  = sel & wr & ~ch_space & (addr[AW-2:0] == (AW-1)'(IDX_STATUS));
  assign en_wr    = sel & wr & ~ch_space & (addr[AW-2:0] == (AW-1)'(IDX_ENABLE));

  logic [NCH-1:0] tx_empty, rx_full, db_pend, ovr;
  logic [NCH-1:0] wr_tx, tx_accept, tx_drop, rx_take, ring, db_clr, ovr_clr;
  logic [NCH-1:0][DATA_W-1:0] tx_data, rx_data;
  logic [NCH-1:0] tx_tog, rx_ack_tog, db_tog;
  logic [EW-1:0]  en_q;

  assign wr_tx     = (sel & wr & ch_space & (ctype == CT_TX_DATA)) ? ch_oh : '0;
  assign tx_accept = wr_tx & tx_empty;
  assign tx_drop   = wr_tx & ~tx_empty;
  assign rx_take   = ((sel & ~wr & ch_space & (ctype == CT_RX_DATA)) ? ch_oh : '0) & rx_full;
  assign ring      = (sel & wr & ch_space & (ctype == CT_TX_BELL) & wdata[0]) ? ch_oh : '0;
  assign db_clr    = ((sel & wr & ch_space & (ctype == CT_RX_BELL) & wdata[0]) ? ch_oh : '0)
                   | (stat_wr ? wdata[3*NCH-1:2*NCH] : '0);
  assign ovr_clr   = stat_wr ? wdata[4*NCH-1:3*NCH] : '0;

  // per-channel state
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_data[i]    <= '0;
        tx_empty[i]   <= 1'b1;
        tx_tog[i]     <= 1'b0;
        ovr[i]        <= 1'b0;
        rx_data[i]    <= '0;
        rx_full[i]    <= 1'b0;
        rx_ack_tog[i] <= 1'b0;
        db_tog[i]     <= 1'b0;
        db_pend[i]    <= 1'b0;
      end else begin
        if (tx_accept[i]) begin
          tx_data[i]  <= wdata;
          tx_empty[i] <= 1'b0;
          tx_tog[i]   <= ~tx_tog[i];
        end else if (tx_ack_i[i]) begin
          tx_empty[i] <= 1'b1;
        end

        if (tx_drop[i])     ovr[i] <= 1'b1;
        else if (ovr_clr[i]) ovr[i] <= 1'b0;

        if (rx_arrive_i[i]) begin
          rx_data[i] <= rx_src_i[i];
          rx_full[i] <= 1'b1;
        end else if (rx_take[i]) begin
          rx_full[i]    <= 1'b0;
          rx_ack_tog[i] <= ~rx_ack_tog[i];
        end

        if (ring[i]) db_tog[i] <= ~db_tog[i];

        // arrival outranks a clear in the same cycle
        if (db_arrive_i[i])  db_pend[i] <= 1'b1;
        else if (db_clr[i])  db_pend[i] <= 1'b0;
      end
    end

    // R5: a dropped write leaves the word in flight untouched
    a_r5_drop_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop[i] |=> $stable(tx_data[i]))
      else $error("a_r5_drop_keeps_word ch %0d", i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wdata[EW-1:0];
  end

  logic [SW-1:0] status;
  assign status = {ovr, db_pend, rx_full, tx_empty};
  assign irq    = |(status[EW-1:0] & en_q);

  always_comb begin
    rdata = '0;
    if (ch_space) begin
      case (ctype)
        CT_RX_DATA: rdata = rx_data[ch];
        CT_RX_BELL: rdata = DATA_W'(db_pend[ch]);
        default:    rdata = '0;
      endcase
    end else if (addr[AW-2:0] == (AW-1)'(IDX_STATUS)) begin
      rdata = DATA_W'(status);
    end else if (addr[AW-2:0] == (AW-1)'(IDX_ENABLE)) begin
      rdata = DATA_W'(en_q);
    end
  end

  assign tx_data_o    = tx_data;
  assign tx_tog_o     = tx_tog;
  assign rx_ack_tog_o = rx_ack_tog;
  assign db_tog_o     = db_tog;

  // R4: consuming a full receive slot empties it
  a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take != '0) |=> ((rx_full & $past(rx_take)) == '0))
    else $error("a_r4_read_clears_full");

  // R7: a doorbell arrival is never lost to a simultaneous clear
  a_r7_arrival_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (db_arrive_i != '0) |=> ((db_pend & $past(db_arrive_i)) == $past(db_arrive_i)))
    else $error("a_r7_arrival_beats_clear");

  // R5: a dropped write always leaves its overrun bit set
  a_r5_drop_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop != '0) |=> ((ovr & $past(tx_drop)) == $past(tx_drop)))
    else $error("a_r5_drop_sets_overrun");

  // R3: transmit-empty only returns on a crossed acknowledge
  a_r3_empty_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_empty & ~$past(tx_empty) & ~$past(tx_ack_i)) == '0))
    else $error("a_r3_empty_only_on_ack");
endmodule

// File: rtl/mu_dual_clk.sv
module mu_dual_clk #(
  parameter int unsigned NCH         = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CH_W        = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int unsigned AW          = CH_W + 3
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  logic [NCH-1:0][DATA_W-1:0] a_txd, b_txd;
  logic [NCH-1:0] a_tx_tog, b_tx_tog, a_ack_tog, b_ack_tog, a_db_tog, b_db_tog;
  logic [NCH-1:0] a_tx_ack, b_tx_ack, a_arrive, b_arrive, a_db_arr, b_db_arr;

  mu_side #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W), .AW(AW)) u_side_a (
    .clk(a_clk), .rst_n(a_rst_n), .sel(a_sel), .wr(a_wr), .addr(a_addr),
    .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq),
    .tx_data_o(a_txd), .tx_tog_o(a_tx_tog), .tx_ack_i(a_tx_ack),
    .rx_arrive_i(a_arrive), .rx_src_i(b_txd), .rx_ack_tog_o(a_ack_tog),
    .db_tog_o(a_db_tog), .db_arrive_i(a_db_arr)
  );

  mu_side #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W), .AW(AW)) u_side_b (
    .clk(b_clk), .rst_n(b_rst_n), .sel(b_sel), .wr(b_wr), .addr(b_addr),
    .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq),
    .tx_data_o(b_txd), .tx_tog_o(b_tx_tog), .tx_ack_i(b_tx_ack),
    .rx_arrive_i(b_arrive), .rx_src_i(a_txd), .rx_ack_tog_o(b_ack_tog),
    .db_tog_o(b_db_tog), .db_arrive_i(b_db_arr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_xing
    // A -> B events
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_a2b_data (
      .dst_clk(b_clk), .dst_rst_n(b_rst_n), .tog_i(a_tx_tog[i]), .pulse_o(b_arrive[i]));
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_a2b_ack (
      .dst_clk(b_clk), .dst_rst_n(b_rst_n), .tog_i(a_ack_tog[i]), .pulse_o(b_tx_ack[i]));
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_a2b_bell (
      .dst_clk(b_clk), .dst_rst_n(b_rst_n), .tog_i(a_db_tog[i]), .pulse_o(b_db_arr[i]));
    // B -> A events
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_b2a_data (
      .dst_clk(a_clk), .dst_rst_n(a_rst_n), .tog_i(b_tx_tog[i]), .pulse_o(a_arrive[i]));
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_b2a_ack (
      .dst_clk(a_clk), .dst_rst_n(a_rst_n), .tog_i(b_ack_tog[i]), .pulse_o(a_tx_ack[i]));
    mu_tgl_sync #(.STAGES(SYNC_STAGES)) u_b2a_bell (
      .dst_clk(a_clk), .dst_rst_n(a_rst_n), .tog_i(b_db_tog[i]), .pulse_o(a_db_arr[i]));
  end
endmodule

// File: tb/mu_dual_clk_tb_top.sv
module mu_dual_clk_tb_top;
  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [4:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  always #4    clk_a = ~clk_a;   // 125 MHz
  always #5.5  clk_b = ~clk_b;   // unrelated second clock

  mu_dual_clk dut_i (
    .a_clk(clk_a), .a_rst_n(rst_n), .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_clk(clk_b), .b_rst_n(rst_n), .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state, index 0 = side A, 1 = side B
  logic [3:0]  m_txe [2], m_rxf [2], m_db [2], m_ovr [2];
  logic [11:0] m_en [2];
  logic [31:0] m_q [2][4][$];   // words waiting at receiving side, per channel

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input int s, input logic [4:0] ad, input logic [31:0] d);
    if (s == 0) begin
      @(negedge clk_a); a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d;
      @(negedge clk_a); a_sel = 0; a_wr = 0;
    end else begin
      @(negedge clk_b); b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d;
      @(negedge clk_b); b_sel = 0; b_wr = 0;
    end
  endtask

  task automatic bus_rd(input int s, input logic [4:0] ad, output logic [31:0] d);
    if (s == 0) begin
      @(negedge clk_a); a_sel = 1; a_wr = 0; a_addr = ad; #1 d = a_rdata;
      @(negedge clk_a); a_sel = 0;
    end else begin
      @(negedge clk_b); b_sel = 1; b_wr = 0; b_addr = ad; #1 d = b_rdata;
      @(negedge clk_b); b_sel = 0;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_b);
  endtask

  function automatic logic [31:0] exp_stat(input int s);
    return {16'h0, m_ovr[s], m_db[s], m_rxf[s], m_txe[s]};
  endfunction

  task automatic chk_side(input int s, input string tag);
    logic [31:0] d;
    bus_rd(s, 5'd16, d);
    check($sformatf("%s status side%0d", tag, s), d, exp_stat(s));
    #1;
    check($sformatf("R8 irq side%0d", s), {31'h0, (s == 0) ? a_irq : b_irq},
          {31'h0, |(exp_stat(s)[11:0] & m_en[s])});
  endtask

  task automatic tx_write(input int s, input int c, input logic [31:0] d);
    bus_wr(s, 5'(c), d);
    if (m_txe[s][c]) begin
      m_txe[s][c] = 1'b0;
      m_q[1-s][c].push_back(d);
      m_rxf[1-s][c] = 1'b1;
    end else begin
      m_ovr[s][c] = 1'b1;
    end
  endtask

  task automatic rx_read(input int s, input int c, input string tag);
    logic [31:0] d;
    bus_rd(s, 5'(4 + c), d);
    if (m_rxf[s][c]) begin
      check($sformatf("%s rx data side%0d ch%0d", tag, s, c), d, m_q[s][c].pop_front());
      m_rxf[s][c] = 1'b0;
      m_txe[1-s][c] = 1'b1;
    end
  endtask

  task automatic set_en(input int s, input logic [11:0] e);
    bus_wr(s, 5'd17, {20'h0, e});
    m_en[s] = e;
  endtask

  initial begin
    logic [31:0] d;
    int seen;
    for (int s = 0; s < 2; s++) begin
      m_txe[s] = 4'hF; m_rxf[s] = 0; m_db[s] = 0; m_ovr[s] = 0; m_en[s] = 0;
    end
    repeat (4) @(negedge clk_a);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_b);

    // R1 reset state
    chk_side(0, "R1");
    chk_side(1, "R1");
    bus_rd(0, 5'd17, d); check("R1 enable side0", d, 32'h0);
    bus_rd(1, 5'd17, d); check("R1 enable side1", d, 32'h0);

    // R2 R3 R9: two channels from A to B
    tx_write(0, 0, 32'hDEADBEEF);
    tx_write(0, 2, 32'h12345678);
    chk_side(0, "R3");
    settle();
    chk_side(1, "R2");
    chk_side(0, "R3");
    rx_read(1, 0, "R4");
    settle();
    chk_side(1, "R4");
    chk_side(0, "R3");
    bus_rd(1, 5'd4, d); check("R4 reread keeps word", d, 32'hDEADBEEF);
    rx_read(1, 2, "R9");
    settle();
    chk_side(0, "R9");

    // R5 overrun
    tx_write(0, 1, 32'h00001111);
    tx_write(0, 1, 32'h00002222);
    chk_side(0, "R5");
    settle();
    rx_read(1, 1, "R5");
    bus_wr(0, 5'd16, 32'h0000_2000);
    m_ovr[0][1] = 1'b0;
    settle();
    chk_side(0, "R5");

    // R10 reverse direction
    tx_write(1, 3, 32'hCAFEF00D);
    chk_side(1, "R10");
    settle();
    chk_side(0, "R10");
    rx_read(0, 3, "R10");
    settle();
    chk_side(1, "R10");

    // R6 R7 R8 doorbell
    bus_wr(0, 5'd9, 32'h1); m_db[1][1] = 1'b1;
    chk_side(0, "R6");
    settle();
    chk_side(1, "R6");
    bus_rd(1, 5'd13, d); check("R7 bell read", d, 32'h1);
    set_en(1, 12'h200);
    chk_side(1, "R8");
    bus_wr(1, 5'd13, 32'h1); m_db[1][1] = 1'b0;
    chk_side(1, "R7");

    // R8 R3 interrupts from data flags
    tx_write(0, 3, 32'h00000055);
    set_en(0, 12'h008);
    chk_side(0, "R8");
    settle();
    set_en(1, 12'h080);
    chk_side(1, "R8");
    rx_read(1, 3, "R8");
    settle();
    chk_side(0, "R8");
    chk_side(1, "R8");
    set_en(0, 12'h000);

    // R7 arrival coinciding with a held clear
    set_en(1, 12'h100);
    seen = 0;
    @(negedge clk_b); b_sel = 1; b_wr = 1; b_addr = 5'd12; b_wdata = 32'h1;
    bus_wr(0, 5'd8, 32'h1);
    repeat (30) begin
      @(negedge clk_b);
      if (b_irq) seen++;
    end
    b_sel = 0; b_wr = 0;
    check("R7 arrival visible under clear", {31'h0, seen > 0}, 32'h1);
    settle();
    chk_side(1, "R7");
    chk_side(0, "R6");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule